// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block takes a 4-bit condition selector and the five status flags (zero, sign, carry, overflow and the sticky saturation flag) and reduces them to one true/false bit. The same bit serves two instruction kinds. A conditional branch uses it to choose the next program counter. A set-on-condition instruction uses it as a 32-bit word that holds exactly 0 or 1.

The block also sign-extends the 9-bit signed branch displacement and adds it to the current program counter to form the branch target. The next program counter is the target when the condition holds. Otherwise it is the current program counter plus the instruction length of two bytes.

With the `REG_OUT` parameter set, which is the default, all outputs are registered. Each result then appears one clock after its inputs, and every output is zero while reset is held. With `REG_OUT` cleared, the outputs are purely combinational.

Top module: `cond_eval`

## Requirements
- R1: Selector values 0, 1, 2, 3 and 4 are true when, respectively, overflow is set, carry is set, zero is set, carry OR zero is set, and sign is set.
- R2: Selector value 5 is true for every flag combination.
- R3: Selector value 6 is true when sign XOR overflow is 1. Selector value 7 is true when zero OR (sign XOR overflow) is 1.
- R4: Selector values 8 through 12 give the inverse of selector values 0 through 4, in the same order.
- R5: Selector value 14 gives the inverse of value 6. Selector value 15 gives the inverse of value 7.
- R6: Selector value 13 is true exactly when the saturation flag is set. The other four flags have no effect on it.
- R7: `target_pc` equals `cur_pc` plus `br_disp`, where `br_disp` is read as a 9-bit two's-complement value (bit 8 is the sign) and sign-extended to 32 bits. The sum wraps modulo 2^32.
- R8: `flag_word` is 32'd1 when the condition holds and 32'd0 otherwise.
- R9: When the condition holds, `next_pc` equals `target_pc`.
- R10: When the condition does not hold, `next_pc` equals `cur_pc` + 2, wrapping modulo 2^32.
- R11: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used when outputs are registered |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| cond_sel | input | 4 | Condition selector, 0 to 15 |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_carry | input | 1 | Carry flag |
| flag_ovf | input | 1 | Overflow flag |
| flag_sat | input | 1 | Sticky saturation flag |
| cur_pc | input | 32 | Program counter of the branch instruction |
| br_disp | input | 9 | Signed branch displacement |
| cond_true | output | 1 | Condition result |
| flag_word | output | 32 | Set-on-condition value, 0 or 1 |
| target_pc | output | 32 | Branch target address |
| next_pc | output | 32 | Selected next program counter |

## Verification
The assertions assume that every input is a known 0 or 1 at each sampling edge. They also assume that, in the registered variant, the inputs captured at one edge are the cause of the outputs seen at the next edge. The inputs are treated as a fresh operand set each cycle, with no protocol between cycles. The bench respects this by changing inputs only on the falling clock edge and by driving every input to a defined value before reset is released. It then checks results one full cycle later.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 9,
  parameter int STEP    = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cond_sel,
  input  logic              flag_zero,
  input  logic              flag_sign,
  input  logic              flag_carry,
  input  logic              flag_ovf,
  input  logic              flag_sat,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [DISP_W-1:0] br_disp,
  output logic              cond_true,
  output logic [XLEN-1:0]   flag_word,
  output logic [XLEN-1:0]   target_pc,
  output logic [XLEN-1:0]   next_pc
);

  localparam int EXT_W = XLEN - DISP_W;

  logic            lt, le, hit;
  logic [XLEN-1:0] disp_x, tgt_c, seq_c, nxt_c, word_c;

  assign lt = flag_sign ^ flag_ovf;
  assign le = flag_zero | lt;

  always_comb begin
    unique case (cond_sel)
      4'd0:  hit = flag_ovf;
      4'd1:  hit = flag_carry;
      4'd2:  hit = flag_zero;
      4'd3:  hit = flag_carry | flag_zero;
      4'd4:  hit = flag_sign;
      4'd5:  hit = 1'b1;
      4'd6:  hit = lt;
      4'd7:  hit = le;
      4'd8:  hit = !flag_ovf;
      4'd9:  hit = !flag_carry;
      4'd10: hit = !flag_zero;
      4'd11: hit = !(flag_carry | flag_zero);
      4'd12: hit = !flag_sign;
      4'd13: hit = flag_sat;
      4'd14: hit = !lt;
      default: hit = !le;
    endcase
  end

  assign disp_x = {{EXT_W{br_disp[DISP_W-1]}}, br_disp};
  assign tgt_c  = cur_pc + disp_x;
  assign seq_c  = cur_pc + XLEN'(STEP);
  assign nxt_c  = hit ? tgt_c : seq_c;
  assign word_c = {{(XLEN-1){1'b0}}, hit};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cond_true <= 1'b0;
          flag_word <= '0;
          target_pc <= '0;
          next_pc   <= '0;
        end else begin
          cond_true <= hit;
          flag_word <= word_c;
          target_pc <= tgt_c;
          next_pc   <= nxt_c;
        end
      end
    end else begin : g_comb
      assign cond_true = hit;
      assign flag_word = word_c;
      assign target_pc = tgt_c;
      assign next_pc   = nxt_c;
    end
  endgenerate

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 9,
  parameter int STEP    = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cond_sel,
  input logic              flag_sat,
  input logic [XLEN-1:0]   cur_pc,
  input logic [DISP_W-1:0] br_disp,
  input logic              cond_true,
  input logic [XLEN-1:0]   flag_word,
  input logic [XLEN-1:0]   target_pc,
  input logic [XLEN-1:0]   next_pc
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  function automatic logic [XLEN-1:0] sx(input logic [DISP_W-1:0] d);
    return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  p_word_binary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> flag_word == {{(XLEN-1){1'b0}}, cond_true});

  p_taken_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cond_true |-> next_pc == target_pc);

  generate
    if (REG_OUT) begin : g_seq
      p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !cond_true |-> next_pc == $past(cur_pc) + XLEN'(STEP));
      p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cond_sel) == 4'd5 |-> cond_true);
      p_sat_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cond_sel) == 4'd13 |-> cond_true == $past(flag_sat));
      p_target_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> target_pc == $past(cur_pc) + sx($past(br_disp)));
      p_reset_zero_r11: assert property (@(posedge clk)
        !armed |-> !cond_true && flag_word == '0 && next_pc == '0);
    end else begin : g_cmb
      p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_true |-> next_pc == cur_pc + XLEN'(STEP));
      p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'd5 |-> cond_true);
      p_sat_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'd13 |-> cond_true == flag_sat);
      p_target_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        target_pc == cur_pc + sx(br_disp));
    end
  endgenerate

endmodule

bind cond_eval cond_eval_chk #(
  .XLEN(XLEN), .DISP_W(DISP_W), .STEP(STEP), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .flag_sat(flag_sat),
  .cur_pc(cur_pc), .br_disp(br_disp), .cond_true(cond_true),
  .flag_word(flag_word), .target_pc(target_pc), .next_pc(next_pc)
);

// File: tb/test_cond_eval.sv
`timescale 1ns/1ps
module test_cond_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic        fz = 1'b0, fs = 1'b0, fc = 1'b0, fo = 1'b0, fsat = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [8:0]  br_disp = '0;
  logic        cond_true;
  logic [31:0] flag_word, target_pc, next_pc;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cond_eval i_cond_eval (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel),
    .flag_zero(fz), .flag_sign(fs), .flag_carry(fc), .flag_ovf(fo), .flag_sat(fsat),
    .cur_pc(cur_pc), .br_disp(br_disp),
    .cond_true(cond_true), .flag_word(flag_word), .target_pc(target_pc), .next_pc(next_pc)
  );

  function automatic string req_of(input int c);
    if (c == 5) return "R2";
    if (c == 13) return "R6";
    if (c == 6 || c == 7) return "R3";
    if (c == 14 || c == 15) return "R5";
    if (c >= 8) return "R4";
    return "R1";
  endfunction

  function automatic bit model(input int c, input bit z, s, cy, ov, sat);
    bit r;
    case (c % 8)
      0: r = ov;
      1: r = cy;
      2: r = z;
      3: r = cy | z;
      4: r = s;
      6: r = s ^ ov;
      7: r = z | (s ^ ov);
      default: r = 1'b1;
    endcase
    if (c == 5) return 1'b1;
    if (c == 13) return sat;
    return (c >= 8) ? !r : r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int c, input logic [4:0] f, input logic [31:0] pc, input logic [8:0] d);
    @(negedge clk);
    cond_sel = 4'(c);
    {fsat, fo, fc, fs, fz} = f;
    cur_pc = pc;
    br_disp = d;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    cond_sel = 4'd5;
    @(negedge clk);
    check("R11 reset cond", {31'd0, cond_true}, 32'd0);
    check("R11 reset word", flag_word, 32'd0);
    check("R11 reset target", target_pc, 32'd0);
    check("R11 reset next", next_pc, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_all_codes;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        bit e;
        e = model(c, f[0], f[1], f[2], f[3], f[4]);
        drive(c, 5'(f), 32'h0000_4000, 9'h010);
        check(req_of(c), {31'd0, cond_true}, {31'd0, e});
        check("R8", flag_word, {31'd0, e});
        check(e ? "R9" : "R10", next_pc, e ? 32'h0000_4010 : 32'h0000_4002);
      end
    end
  endtask

  task automatic t_displacement;
    drive(5, 5'd0, 32'h0000_1000, 9'h0FF);
    check("R7 max positive", target_pc, 32'h0000_10FF);
    check("R9 max positive", next_pc, 32'h0000_10FF);
    drive(5, 5'd0, 32'h0000_1000, 9'h100);
    check("R7 most negative", target_pc, 32'h0000_0F00);
    drive(5, 5'd0, 32'h0000_1000, 9'h1FE);
    check("R7 minus two", target_pc, 32'h0000_0FFE);
    drive(5, 5'd0, 32'hFFFF_FFFE, 9'h004);
    check("R7 wrap", target_pc, 32'h0000_0002);
    drive(13, 5'b01111, 32'hFFFF_FFFE, 9'h100);
    check("R6 sat clear", {31'd0, cond_true}, 32'd0);
    check("R10 wrap", next_pc, 32'h0000_0000);
    check("R7 not taken target", target_pc, 32'hFFFF_FEFE);
  endtask

  task automatic t_latency;
    @(negedge clk);
    cond_sel = 4'd13; fsat = 1'b1; cur_pc = 32'h0000_2000; br_disp = 9'h020;
    @(posedge clk);
    #1;
    cond_sel = 4'd13; fsat = 1'b0;
    check("R11 one cycle", {31'd0, cond_true}, 32'd1);
    @(negedge clk);
    check("R11 next edge", {31'd0, cond_true}, 32'd1);
    @(posedge clk);
    #1;
    check("R11 follows", {31'd0, cond_true}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_all_codes();
    t_displacement();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule